// File: doc/BRIEF.md
# Posted Write Burst Sequencer

This block moves a posted write burst from an on-chip command and write-data buffer onto a simplified bus master transaction port. A command gives a byte start address, a length in DWORDs and a bus-width choice (32-bit or 64-bit data phases). The block splits the burst into one or more bus transactions. Each one is sized from how much data the buffer holds when it is requested. After each transaction the block reads the termination code the bus reports and decides what to do next: finish, wait for more data, re-issue from the point reached, or discard what is left.

Commands enter through a valid/ready pair. `cmd_ready` is high only when no burst is in progress, and a command is taken on a cycle where both signals are high. Transaction requests leave through a second valid/ready pair. Once `txn_valid` is raised, it stays high with `txn_addr` and `txn_len` unchanged until the bus raises `txn_ready`. Data phases (`bus_beat`), the transaction end strobe (`bus_end`) and the buffer pop strobe are plain single-cycle pulses with no back-pressure. The bus never issues more beats than `txn_len` allows, and never raises a beat and the end strobe in the same cycle.

Top module: `wr_burst_ctl`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `txn_valid`, `buf_pop`, `done_ok` and `done_err` are 0. `cmd_ready` is 1 exactly when no burst is active, and it is never high together with `txn_valid`.
- R2: A transaction is requested only when `buf_level` (in DWORDs) is at least 8 in 32-bit mode or at least 16 in 64-bit mode, or when it is at least the number of DWORDs still owed. This applies both to the first segment and after a stall.
- R3: `txn_len` is the remaining count when the buffer covers all of it. Otherwise it is `buf_level`, rounded down to an even number in 64-bit mode. It is never zero.
- R4: While `txn_valid` is high and `txn_ready` is low, the request stays up with `txn_addr` and `txn_len` unchanged.
- R5: During a transaction, `buf_pop` follows `bus_beat` one for one. Each pop removes one DWORD in 32-bit mode (`wide_mode`=0) and two in 64-bit mode (`wide_mode`=1). Outside a transaction or a drain, `buf_pop` stays low.
- R6: `bus_term` code 0 is a normal end. If DWORDs are still owed, the next request starts at the address advanced by 4 bytes per DWORD accepted, its length drawn from the reduced remaining count, and it waits for the gate in R2 first.
- R7: Codes 1 (target disconnect) and 2 (target retry) cause the write to be requested again from the advanced address, for as many rounds as it takes to complete.
- R8: Codes 3 (target-abort), 4 (master-abort) and 5 to 7 (treated as aborts) cause the rest of the burst to be popped and dropped, one data phase per cycle whenever the buffer holds one. Then `done_err` pulses for one cycle and `cmd_ready` returns.
- R9: `done_ok` pulses for one cycle, in the cycle after the `bus_end` that delivers the last owed DWORD.
- R10: A command with length 0, or with an odd length in 64-bit mode, starts no transaction. It produces a `done_err` pulse in the next cycle, and `cmd_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_addr | input | ADDR_W | Byte start address of the burst |
| cmd_len | input | CNT_W | Burst length in DWORDs |
| wide_mode | input | 1 | 1 = 64-bit data phases, 0 = 32-bit |
| buf_level | input | LVL_W | DWORDs held in the write buffer |
| buf_pop | output | 1 | Remove one data phase from the buffer |
| txn_valid | output | 1 | Transaction request |
| txn_ready | input | 1 | Bus accepts the request |
| txn_addr | output | ADDR_W | Byte address of the request |
| txn_len | output | CNT_W | DWORDs in the request |
| bus_beat | input | 1 | One data phase accepted by the target |
| bus_end | input | 1 | Transaction finished |
| bus_term | input | 3 | Termination code, valid with bus_end |
| done_ok | output | 1 | Burst completed pulse |
| done_err | output | 1 | Burst aborted or command rejected pulse |

## Verification
The bench targets the stall gate at its exact thresholds. A gate that ignored the remaining-count rule would hang a short 64-bit burst with 12 DWORDs buffered. A gate that used the wrong width threshold would issue a 7-DWORD or 9-DWORD first segment when the level climbs one DWORD per cycle. A disconnect after two beats, followed by a retry with none, checks that the address advances by 8 bytes and then does not move, so a design that restarted from the original address, or counted the retry as progress, would mismatch. Aborts with codes 3 and 6 partway through a burst check that every leftover data phase is popped before `done_err`, which catches both a design that stops popping early and one that raises `cmd_ready` before the drain ends.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER,
    ST_DRAIN
  } wbc_state_t;

  localparam logic [2:0] TERM_NORMAL = 3'd0;
  localparam logic [2:0] TERM_DISC   = 3'd1;
  localparam logic [2:0] TERM_RETRY  = 3'd2;
  localparam logic [2:0] TERM_TABORT = 3'd3;
  localparam logic [2:0] TERM_MABORT = 3'd4;
endpackage

// File: rtl/wbc_seg_calc.sv
// Decides whether a segment may start and how long it is.
module wbc_seg_calc #(
  parameter int CNT_W      = 12,
  parameter int LVL_W      = 8,
  parameter int THR_NARROW = 8,
  parameter int THR_WIDE   = 16
) (
  input  logic [LVL_W-1:0] level,
  input  logic [CNT_W-1:0] rem,
  input  logic             wide,
  output logic             go,
  output logic [CNT_W-1:0] seg_len
);
  localparam int CW = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [CW-1:0] lvl_x, rem_x, thr_x, lvl_fl;
  logic          covers;

  always_comb begin
    lvl_x  = CW'(level);
    rem_x  = CW'(rem);
    thr_x  = wide ? CW'(THR_WIDE) : CW'(THR_NARROW);
    lvl_fl = wide ? {lvl_x[CW-1:1], 1'b0} : lvl_x;
    covers = (lvl_x >= rem_x);
    go     = covers || (lvl_x >= thr_x);
    seg_len = covers ? rem : CNT_W'(lvl_fl);
  end
endmodule

// File: rtl/wbc_beat_ctr.sv
// Counts DWORDs accepted in the current transaction.
module wbc_beat_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] taken,
  output logic [CNT_W-1:0] taken_nxt
);
  assign taken_nxt = taken + (inc ? step : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   taken <= '0;
    else if (clr) taken <= '0;
    else          taken <= taken_nxt;
  end
endmodule

// File: rtl/wr_burst_ctl.sv
module wr_burst_ctl
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 12,
  parameter int LVL_W      = 8,
  parameter int THR_NARROW = 8,
  parameter int THR_WIDE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_len,
  input  logic              wide_mode,
  input  logic [LVL_W-1:0]  buf_level,
  output logic              buf_pop,
  output logic              txn_valid,
  input  logic              txn_ready,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [CNT_W-1:0]  txn_len,
  input  logic              bus_beat,
  input  logic              bus_end,
  input  logic [2:0]        bus_term,
  output logic              done_ok,
  output logic              done_err
);
  wbc_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q, seg_q, step, taken, tk, seg_len;
  logic              wide_q, go, bad_cmd, is_abort, lvl_has_phase, in_xfer;

  assign step          = wide_q ? CNT_W'(2) : CNT_W'(1);
  assign bad_cmd       = (cmd_len == '0) || (wide_mode && cmd_len[0]);
  assign is_abort      = (bus_term >= TERM_TABORT);
  assign lvl_has_phase = wide_q ? (buf_level >= LVL_W'(2)) : (buf_level != '0);
  assign in_xfer       = (st == ST_XFER);

  assign cmd_ready = (st == ST_IDLE);
  assign txn_valid = (st == ST_REQ);
  assign txn_addr  = addr_q;
  assign txn_len   = seg_q;
  assign buf_pop   = (in_xfer && bus_beat) || ((st == ST_DRAIN) && lvl_has_phase);

  wbc_seg_calc #(
    .CNT_W(CNT_W), .LVL_W(LVL_W), .THR_NARROW(THR_NARROW), .THR_WIDE(THR_WIDE)
  ) u_seg (
    .level(buf_level), .rem(rem_q), .wide(wide_q), .go(go), .seg_len(seg_len)
  );

  wbc_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_REQ), .inc(in_xfer && bus_beat),
    .step(step), .taken(taken), .taken_nxt(tk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      seg_q    <= '0;
      wide_q   <= 1'b0;
      done_ok  <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done_ok  <= 1'b0;
      done_err <= 1'b0;
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          if (bad_cmd) done_err <= 1'b1;
          else begin
            addr_q <= cmd_addr;
            rem_q  <= cmd_len;
            wide_q <= wide_mode;
            st     <= ST_WAIT;
          end
        end
        ST_WAIT: if (go) begin
          seg_q <= seg_len;
          st    <= ST_REQ;
        end
        ST_REQ: if (txn_ready) st <= ST_XFER;
        ST_XFER: if (bus_end) begin
          rem_q  <= rem_q - tk;
          addr_q <= addr_q + (ADDR_W'(tk) << 2);
          if (rem_q == tk) begin
            st <= ST_IDLE;
            if (is_abort) done_err <= 1'b1;
            else          done_ok  <= 1'b1;
          end else begin
            st <= is_abort ? ST_DRAIN : ST_WAIT;
          end
        end
        ST_DRAIN: if (lvl_has_phase) begin
          rem_q <= rem_q - step;
          if (rem_q == step) begin
            done_err <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CNT_W-1:0]  cmd_len,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [CNT_W-1:0]  txn_len,
  input logic              buf_pop,
  input logic              done_ok,
  input logic              done_err
);
  // R1
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && txn_valid));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_len)));

  // R3
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_len != '0));

  // R5
  pop_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> (!cmd_ready && !txn_valid));

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_len == '0) |=> (done_err && cmd_ready));
endmodule

bind wr_burst_ctl wbc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_len(cmd_len), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_addr(txn_addr), .txn_len(txn_len), .buf_pop(buf_pop),
  .done_ok(done_ok), .done_err(done_err)
);

// File: tb/sim_wr_burst_ctl.sv
module sim_wr_burst_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, wide_mode = 1'b0, txn_ready = 1'b0;
  logic        bus_beat = 1'b0, bus_end = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [11:0] cmd_len = '0;
  logic [7:0]  buf_level = '0;
  logic [2:0]  bus_term = '0;
  logic        cmd_ready, buf_pop, txn_valid, done_ok, done_err;
  logic [31:0] txn_addr;
  logic [11:0] txn_len;

  always #4 clk = ~clk;

  wr_burst_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wide_mode(wide_mode),
    .buf_level(buf_level), .buf_pop(buf_pop), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_len(txn_len),
    .bus_beat(bus_beat), .bus_end(bus_end), .bus_term(bus_term),
    .done_ok(done_ok), .done_err(done_err)
  );

  int checks = 0, fails = 0;
  // reference model state: 0 idle, 1 wait, 2 request, 3 transfer, 4 drain
  int m_st = 0, m_rem = 0, m_seg = 0, m_taken = 0;
  longint m_addr = 0;
  bit m_wide = 0, m_dok = 0, m_derr = 0;
  bit have_cmd = 0, c_wide = 0;
  longint c_addr = 0;
  int c_len = 0;
  int lvl = 0, fill = 0, cap = 0, rdy_wait = 0, rdy_cnt = 0;
  int ag_beats = 0, ag_cnt = 0, ag_term = 0;
  int plan_term[$], plan_beats[$];
  int n_start = 0, n_stall = 0, first_len = -1, n_dok = 0, n_derr = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int e_step, tk, thr;
    bit e_pop;
    @(negedge clk);
    e_step    = m_wide ? 2 : 1;
    cmd_valid = (m_st == 0) && have_cmd;
    cmd_addr  = c_addr[31:0];
    cmd_len   = 12'(c_len);
    wide_mode = c_wide;
    buf_level = 8'(lvl);
    txn_ready = (m_st == 2) && (rdy_cnt >= rdy_wait);
    bus_beat  = (m_st == 3) && (ag_cnt < ag_beats);
    bus_end   = (m_st == 3) && (ag_cnt >= ag_beats);
    bus_term  = 3'(ag_term);
    #1;
    e_pop = (m_st == 3 && bus_beat) || (m_st == 4 && lvl >= e_step);
    chk("R1", "cmd_ready", cmd_ready, m_st == 0);
    chk("R2", "txn_valid", txn_valid, m_st == 2);
    if (m_st == 2) begin
      chk("R6", "txn_addr", txn_addr, m_addr);
      chk("R3", "txn_len", txn_len, m_seg);
    end
    chk("R5", "buf_pop", buf_pop, e_pop);
    chk("R9", "done_ok", done_ok, m_dok);
    chk("R8", "done_err", done_err, m_derr);
    if (txn_valid && txn_ready) begin
      n_start++;
      if (first_len < 0) first_len = txn_len;
    end
    if (txn_valid && !txn_ready) n_stall++;
    if (done_ok) n_dok++;
    if (done_err) n_derr++;
    m_dok = 0;
    m_derr = 0;
    case (m_st)
      0: if (cmd_valid) begin
        have_cmd = 0;
        if (c_len == 0 || (c_wide && (c_len % 2) == 1)) m_derr = 1;
        else begin
          m_addr = c_addr; m_rem = c_len; m_wide = c_wide; m_st = 1;
        end
      end
      1: begin
        thr = m_wide ? 16 : 8;
        if (lvl >= thr || lvl >= m_rem) begin
          m_seg = (lvl >= m_rem) ? m_rem : (m_wide ? (lvl / 2) * 2 : lvl);
          m_st = 2;
          rdy_cnt = 0;
        end
      end
      2: if (txn_ready) begin
        m_st = 3; m_taken = 0; ag_cnt = 0;
        if (plan_term.size() > 0) begin
          ag_term = plan_term.pop_front();
          ag_beats = plan_beats.pop_front();
        end else begin
          ag_term = 0;
          ag_beats = m_seg / e_step;
        end
      end else rdy_cnt++;
      3: begin
        tk = m_taken + (bus_beat ? e_step : 0);
        if (bus_end) begin
          m_rem -= tk;
          m_addr += 4 * tk;
          if (m_rem == 0) begin
            if (ag_term <= 2) m_dok = 1; else m_derr = 1;
            m_st = 0;
          end else m_st = (ag_term <= 2) ? 1 : 4;
        end else begin
          m_taken = tk;
          ag_cnt++;
        end
      end
      4: if (lvl >= e_step) begin
        m_rem -= e_step;
        if (m_rem == 0) begin m_derr = 1; m_st = 0; end
      end
      default: m_st = 0;
    endcase
    if (e_pop) lvl -= e_step;
    if (lvl < cap) lvl = (lvl + fill > cap) ? cap : lvl + fill;
  endtask

  task automatic run(input longint a, input int len, input bit w);
    c_addr = a; c_len = len; c_wide = w; have_cmd = 1;
    n_start = 0; n_stall = 0; first_len = -1; n_dok = 0; n_derr = 0;
    cyc();
    while (have_cmd || m_st != 0) cyc();
    cyc();
    cyc();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset cmd_ready", cmd_ready, 1);
    chk("R1", "reset txn_valid", txn_valid, 0);
    chk("R1", "reset buf_pop", buf_pop, 0);
    chk("R1", "reset done", {done_ok, done_err}, 0);
    rst_n = 1'b1;

    // plain 32-bit burst, buffer already full
    lvl = 20; cap = 20; fill = 0;
    run(64'h1000, 8, 0);
    chk("R9", "single segment count", n_start, 1);
    chk("R9", "done_ok pulses", n_dok, 1);

    // slow refill with delayed bus acceptance
    lvl = 5; cap = 64; fill = 1; rdy_wait = 3;
    run(64'h2000, 20, 0);
    chk("R2", "first segment at 32-bit threshold", first_len, 8);
    chk("R4", "held request cycles", n_stall, 3 * n_start);
    rdy_wait = 0;

    // 64-bit, level below threshold but covers the burst
    lvl = 12; cap = 12; fill = 0;
    run(64'h3000, 10, 1);
    chk("R2", "remaining-count gate", first_len, 10);

    // 64-bit, odd level rounded down
    lvl = 17; cap = 17; fill = 1;
    run(64'h4000, 40, 1);
    chk("R3", "even 64-bit segment", first_len, 16);

    // disconnect after two beats, then a retry, then success
    lvl = 16; cap = 16; fill = 1;
    plan_term.push_back(1); plan_beats.push_back(2);
    plan_term.push_back(2); plan_beats.push_back(0);
    run(64'h5000, 12, 0);
    chk("R7", "re-issued requests", n_start, 3);
    chk("R7", "completed after retries", n_dok, 1);

    // target-abort partway, drain the rest
    lvl = 8; cap = 8; fill = 1;
    plan_term.push_back(3); plan_beats.push_back(3);
    run(64'h6000, 12, 0);
    chk("R8", "abort reports error", n_derr, 1);
    chk("R8", "abort no done_ok", n_dok, 0);

    // unused code treated as abort, 64-bit drain empties buffer
    lvl = 6; cap = 6; fill = 0;
    plan_term.push_back(6); plan_beats.push_back(1);
    run(64'h7000, 6, 1);
    chk("R8", "code 6 aborts", n_derr, 1);
    chk("R5", "all data popped", lvl, 0);

    // rejected commands
    lvl = 40; cap = 40; fill = 0;
    run(64'h8000, 5, 1);
    chk("R10", "odd 64-bit length no txn", n_start, 0);
    chk("R10", "odd 64-bit length error", n_derr, 1);
    run(64'h8000, 0, 0);
    chk("R10", "zero length no txn", n_start, 0);
    chk("R10", "zero length error", n_derr, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule